// File: doc/BRIEF.md
# Alternating Pattern Sequencer

This block plays a bit pattern from internal storage as a serial stream, one bit per clock. Two pattern banks of equal length are written through a word-wide write port. The active bank repeats without end. A swap request can come from a panel control (active high) or from an auxiliary line (active low). The request is stored as pending. The swap takes effect when the current pass through the pattern ends, so a pattern is never cut short.

The pattern length is set in whole 128-bit blocks and applies to both banks. When a swap is applied, a trigger output goes high for sixteen clock cycles. The trigger goes high in the same cycle that the first bit of the new pattern appears on the serial output. Both request inputs are level-sampled through a synchronizer. A request counts once, when its combined level is first seen high. Any further requests before the boundary merge into the same single swap.

Top module: `altpat_seq`

## Requirements
- R1: While reset is held, `dout` and `trig` are 0. The first clock edge after reset is released presents bit 0 of bank 0 on `dout`. Each later edge presents the next bit.
- R2: Bit i of a bank is bit (i mod 16) of the 16-bit word at address i/16 in that bank. A word is written on an edge where `wr_en` is 1, into bank `wr_bank` (0 or 1) at `wr_addr`.
- R3: A `len_blocks` value N from 1 to 4 gives a pattern of N*128 bits. A value of 0 gives 128 bits, and values above 4 give 512 bits. After the last bit the pattern restarts at bit 0.
- R4: With no request, the same bank repeats indefinitely and `trig` stays 0.
- R5: A swap only takes place at a pattern boundary. The bit after the last bit of the old bank is bit 0 of the other bank.
- R6: A request is a high level on `panel_swap` or a low level on `aux_swap_n`. Only the start of the combined request level counts, so a level held across several boundaries causes exactly one swap.
- R7: A request whose level is first sampled at edge e is applied at the boundary whose last bit is loaded at an edge no earlier than e+2. Otherwise it is held pending for the following boundary.
- R8: Several requests made within one pattern pass cause a single swap.
- R9: On a swap, `trig` is 1 for exactly 16 cycles, starting in the cycle in which bit 0 of the new bank first appears.
- R10: The pending request is cleared when its swap is applied. A swap back needs a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Pattern word write strobe |
| wr_bank | input | 1 | Bank selected for the write |
| wr_addr | input | 5 | Word address within the bank |
| wr_data | input | 16 | Pattern word, LSB is the earlier bit |
| len_blocks | input | 3 | Pattern length in 128-bit blocks |
| panel_swap | input | 1 | Panel swap request, active high |
| aux_swap_n | input | 1 | Auxiliary swap request, active low |
| dout | output | 1 | Serial pattern bit |
| trig | output | 1 | Swap marker, 16 cycles wide |

## Verification
The hardest case is a request that arrives just before a boundary. The synchronizer delay decides whether that request catches the current boundary or waits for the next one. The stimulus waits until a chosen bit index is shown on `dout` and then raises the request. Two cases sit one cycle apart on either side of the cutoff, five and four bits before the end. Further cases hold one level across several boundaries, send two requests in one pass, and ask for a second swap in the following pass.

// File: rtl/altpat_pkg.sv
package altpat_pkg;

  // Number of 128-bit blocks actually used for a programmed length value.
  function automatic int unsigned eff_blocks(input int unsigned len, input int unsigned max_blocks);
    if (len == 0) return 1;
    if (len > max_blocks) return max_blocks;
    return len;
  endfunction

  // Index of the last bit of a pattern of the programmed length.
  function automatic int unsigned last_bit_index(input int unsigned len,
                                                 input int unsigned max_blocks,
                                                 input int unsigned block_bits);
    return eff_blocks(len, max_blocks) * block_bits - 1;
  endfunction

endpackage

// File: rtl/altpat_store.sv
module altpat_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 32,
  parameter int AW     = 5,
  parameter int PW     = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [PW-1:0]     rd_ptr,
  output logic              rd_bit
);
  localparam int BW = $clog2(WORD_W);
  localparam int NBANK = 2;

  logic [AW-1:0] rd_word;
  logic [BW-1:0] rd_sel;
  logic [NBANK-1:0] bank_bit;

  assign rd_word = rd_ptr[PW-1:BW];
  assign rd_sel  = rd_ptr[BW-1:0];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(g))) mem[wr_addr] <= wr_data;
    end
    assign bank_bit[g] = mem[rd_word][rd_sel];
  end

  assign rd_bit = bank_bit[rd_bank];
endmodule

// File: rtl/altpat_reqsync.sv
module altpat_reqsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic panel_swap,
  input  logic aux_swap_n,
  output logic req_rise
);
  // bit 0: panel request, bit 1: auxiliary request (made active high)
  logic [1:0] stg [SYNC_STAGES];
  logic       lvl, lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 2'b00;
      lvl_q <= 1'b0;
    end else begin
      stg[0] <= {~aux_swap_n, panel_swap};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      lvl_q <= lvl;
    end
  end

  assign lvl      = |stg[SYNC_STAGES-1];
  assign req_rise = lvl & ~lvl_q;
endmodule

// File: rtl/altpat_player.sv
module altpat_player #(
  parameter int PW     = 9,
  parameter int TRIG_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] last_idx,
  input  logic          req_rise,
  output logic [PW-1:0] ptr,
  output logic          bank,
  output logic          wrap_ev,
  output logic          take_ev,
  output logic          pending,
  output logic          trig
);
  localparam int TCW = $clog2(TRIG_W + 1);

  logic           swap_d;
  logic [TCW-1:0] trig_cnt;

  assign wrap_ev = (ptr >= last_idx);
  assign take_ev = wrap_ev & (pending | req_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      bank     <= 1'b0;
      pending  <= 1'b0;
      swap_d   <= 1'b0;
      trig_cnt <= '0;
    end else begin
      ptr     <= wrap_ev ? '0 : ptr + 1'b1;
      bank    <= take_ev ? ~bank : bank;
      pending <= take_ev ? 1'b0 : (pending | req_rise);
      swap_d  <= take_ev;
      if (swap_d)              trig_cnt <= TCW'(TRIG_W);
      else if (trig_cnt != 0)  trig_cnt <= trig_cnt - 1'b1;
    end
  end

  assign trig = (trig_cnt != 0);
endmodule

// File: rtl/altpat_seq.sv
module altpat_seq #(
  parameter int BLOCK_BITS  = 128,
  parameter int MAX_BLOCKS  = 4,
  parameter int WORD_W      = 16,
  parameter int TRIG_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int MAX_BITS = BLOCK_BITS * MAX_BLOCKS,
  localparam int DEPTH    = MAX_BITS / WORD_W,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = $clog2(MAX_BITS),
  localparam int LW       = $clog2(MAX_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LW-1:0]     len_blocks,
  input  logic              panel_swap,
  input  logic              aux_swap_n,
  output logic              dout,
  output logic              trig
);
  import altpat_pkg::*;

  logic [PW-1:0] last_idx;
  logic [PW-1:0] ptr;
  logic          bank, wrap_ev, take_ev, pending, req_rise, rd_bit;

  assign last_idx = PW'(last_bit_index(int'(len_blocks), MAX_BLOCKS, BLOCK_BITS));

  altpat_reqsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .panel_swap(panel_swap), .aux_swap_n(aux_swap_n),
    .req_rise(req_rise)
  );

  altpat_player #(.PW(PW), .TRIG_W(TRIG_W)) u_play (
    .clk(clk), .rst(rst), .last_idx(last_idx), .req_rise(req_rise),
    .ptr(ptr), .bank(bank), .wrap_ev(wrap_ev), .take_ev(take_ev),
    .pending(pending), .trig(trig)
  );

  altpat_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_bank(bank), .rd_ptr(ptr), .rd_bit(rd_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= rd_bit;
  end
endmodule

// File: rtl/altpat_seq_chk.sv
module altpat_seq_chk #(
  parameter int PW     = 9,
  parameter int TRIG_W = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] ptr,
  input logic          bank,
  input logic          wrap_ev,
  input logic          take_ev,
  input logic          pending,
  input logic          trig
);
  localparam int RW = $clog2(TRIG_W + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (trig) run <= run + 1'b1;
    else           run <= '0;
  end

  // R5
  bank_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bank) |-> $past(wrap_ev));

  // R3
  restart_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wrap_ev) |-> (ptr == '0));

  // R10
  pending_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $past(take_ev) |-> !pending);

  // R9
  trig_follows_swap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trig) |-> $past(take_ev, 2));

  // R9
  trig_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(trig) |-> (run == RW'(TRIG_W)));

  // R9
  trig_not_long_chk: assert property (@(posedge clk) disable iff (rst)
    trig |-> (run < RW'(TRIG_W)));
endmodule

bind altpat_seq altpat_seq_chk #(.PW(PW), .TRIG_W(TRIG_W)) u_chk (
  .clk(clk), .rst(rst), .ptr(ptr), .bank(bank), .wrap_ev(wrap_ev),
  .take_ev(take_ev), .pending(pending), .trig(trig)
);

// File: tb/altpat_seq_bench.sv
module altpat_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_bank = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  len_blocks = 3'd1;
  logic        panel_swap = 1'b0;
  logic        aux_swap_n = 1'b1;
  logic        dout, trig;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  altpat_seq u_altpat_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .len_blocks(len_blocks), .panel_swap(panel_swap),
    .aux_swap_n(aux_swap_n), .dout(dout), .trig(trig)
  );

  always #5 clk = ~clk;

  // Reference patterns, from the requirements only
  function automatic logic pat(input int b, input int i);
    logic p0;
    p0 = 1'(((i * 7) ^ (i >> 2)) & 1);
    if (b == 0) return p0;
    return (i % 4 == 0) ? p0 : ~p0;
  endfunction

  function automatic int exp_len(input int n);
    if (n == 0) return 128;
    if (n > 4) return 512;
    return n * 128;
  endfunction

  // Stimulus table: length value, source (0 panel, 1 aux), bits before end, boundaries skipped
  localparam int NV = 6;
  localparam int V_LEN [NV]  = '{1, 1, 1, 2, 0, 7};
  localparam int V_SRC [NV]  = '{0, 1, 1, 0, 1, 0};
  localparam int V_OFF [NV]  = '{60, 5, 4, 100, 30, 200};
  localparam int V_SKIP [NV] = '{0, 0, 1, 0, 0, 0};

  // Monitor state
  logic  rst_seen = 1'b1;
  int    cur_L = 128;
  int    mon_idx = 0, mon_bank = 0, mon_trig = 0, mon_shown = -1;
  int    swap_due = 0, swap_skip = 0;
  string tag = "R1";

  task automatic check(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b idx=%0d bank=%0d", t, what, act, exp, mon_idx, mon_bank);
    end
  endtask

  always @(posedge clk) begin
    rst_seen <= rst;
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_seen) begin
      check("R1", dout, 1'b0, "dout in reset");
      check("R1", trig, 1'b0, "trig in reset");
      mon_idx = 0; mon_bank = 0; mon_trig = 0; mon_shown = -1;
    end else begin
      // R2 R5 data stream, R9 trigger window
      check(tag, dout, pat(mon_bank, mon_idx), "R2/R5 dout bit");
      check(tag, trig, 1'(mon_trig > 0), "R9 trig");
      mon_shown = mon_idx;
      if (mon_trig > 0) mon_trig--;
      if (mon_idx == cur_L - 1) begin
        mon_idx = 0;
        if (swap_due != 0) begin
          if (swap_skip > 0) swap_skip--;
          else begin
            mon_bank ^= 1; swap_due = 0; mon_trig = 16;
          end
        end
      end else mon_idx++;
    end
  end

  task automatic do_reset(input int n);
    @(posedge clk); #2;
    rst = 1'b1; len_blocks = 3'(n); cur_L = exp_len(n);
    swap_due = 0; swap_skip = 0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  task automatic wait_shown(input int k, input int b);
    do begin
      @(negedge clk); #1;
    end while (mon_shown != k || mon_bank != b);
  endtask

  task automatic request(input int src, input int hold, input int skip);
    @(posedge clk); #2;
    if (src == 0) panel_swap = 1'b1; else aux_swap_n = 1'b0;
    if (swap_due == 0) swap_skip = skip;
    swap_due = 1;
    repeat (hold) @(posedge clk);
    #2 panel_swap = 1'b0; aux_swap_n = 1'b1;
  endtask

  initial begin
    // R2: load both banks, LSB of each word is the earlier bit
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 32; w++) begin
        @(posedge clk); #2;
        wr_en = 1'b1; wr_bank = 1'(b); wr_addr = 5'(w);
        for (int k = 0; k < 16; k++) wr_data[k] = pat(b, w * 16 + k);
      end
    end
    @(posedge clk); #2 wr_en = 1'b0;

    // Table walk: R3 lengths, R6 sources, R7 cutoff (offsets 5 and 4)
    for (int v = 0; v < NV; v++) begin
      tag = (v == 1 || v == 2) ? "R7" : ((v == 4 || v == 5) ? "R3" : "R6");
      do_reset(V_LEN[v]);
      wait_shown(exp_len(V_LEN[v]) - V_OFF[v], 0);
      request(V_SRC[v], 20, V_SKIP[v]);
      repeat (3 * exp_len(V_LEN[v]) + 40) @(posedge clk);
    end

    // R4: no request, bank 0 repeats, no trigger
    tag = "R4";
    do_reset(1);
    repeat (3 * 128 + 20) @(posedge clk);

    // R8: two requests in one pass, one swap
    tag = "R8";
    do_reset(1);
    wait_shown(10, 0);
    request(0, 5, 0);
    wait_shown(40, 0);
    request(1, 5, 0);
    repeat (3 * 128) @(posedge clk);

    // R6: a level held over several boundaries swaps once
    tag = "R6";
    do_reset(1);
    wait_shown(10, 0);
    request(1, 450, 0);
    repeat (2 * 128) @(posedge clk);

    // R10: swap, then a new request in the next pass swaps back
    tag = "R10";
    do_reset(1);
    wait_shown(10, 0);
    request(0, 5, 0);
    wait_shown(10, 1);
    request(1, 5, 0);
    repeat (3 * 128) @(posedge clk);

    // R1: reset in mid-run returns to bank 0 bit 0
    tag = "R1";
    do_reset(2);
    repeat (300) @(posedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule